// File: doc/BRIEF.md
# Serial DAC Word Loader

This block turns a signed sample into a bit-serial write for a 20-bit digital-to-analog converter that is wired by three lines: serial data, shift clock and a latch-enable strobe. A client offers a value through a valid/ready handshake, together with the length of the time slot the write may take and a clock-divider count that sets how long each output phase lasts. The block checks the value and the slot. It then shifts the 20-bit word out, most significant bit first. Each bit takes two phases: clock high, then clock low, with the data held across both. One final phase with every line low makes the converter take the word.

Two sequence pulses, one for the start and one for the end of an experiment, each run a zero load. This load shifts twenty zero bits with the latch strobe held low, ends with the same all-low phase, and then raises the strobe. When no load is running, the strobe sits high and the clock and data sit low. A one-cycle done pulse marks the end of every load. An error flag reports a refused request.

Top module: `dac_word_loader`

## Requirements
- R1: After reset, dac_le is 1, dac_sclk and dac_sdata are 0, req_ready is 1, and busy, done and error are 0.
- R2: A data load runs 40 shift phases. In phase 2k (k = 0..19), dac_sclk is 1 and dac_sdata carries bit 19-k of the word, so the most significant bit goes first. In phase 2k+1, dac_sclk is 0 and dac_sdata holds the same bit. The word is req_value[19:0], sent uninverted.
- R3: During the 40 shift phases of a data load, dac_le stays 1.
- R4: Phase 40 drives dac_sdata, dac_sclk and dac_le all to 0. In the next cycle dac_le returns to 1, busy falls and done is 1 for exactly one cycle. A load therefore lasts 41 phases.
- R5: Each phase lasts div_count+1 clock cycles. div_count is captured when the load starts, and a change to it during a load has no effect.
- R6: A request whose req_value (24-bit two's complement) is below -2^19 or above 2^19-1 sets error and starts no shift. dac_sclk stays 0 and dac_le stays 1.
- R7: A request whose req_slot is less than 41 sets error and starts no shift. A slot of exactly 41 is accepted.
- R8: A pulse on seq_start or seq_end while idle starts a zero load. It runs 40 phases with dac_sdata 0, dac_le 0 and dac_sclk toggling as in R2, then the all-low phase 40, then dac_le returns to 1 with a done pulse.
- R9: req_ready is 1 only while idle and busy is 1 throughout a load. A request, a sequence pulse or a div_count change offered during a load leaves that load's output stream unchanged.
- R10: error stays set until the next accepted request. An accepted request that is in range and has a long enough slot clears it.
- R11: When a sequence pulse and a request arrive in the same idle cycle, the zero load wins, req_ready is 0 in that cycle and the request is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seq_start | input | 1 | Start-of-sequence pulse, runs a zero load |
| seq_end | input | 1 | End-of-sequence pulse, runs a zero load |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_value | input | 24 | Signed sample value |
| req_slot | input | 12 | Slot length in phase periods |
| div_count | input | 8 | Phase period minus one, in clock cycles |
| dac_sdata | output | 1 | Serial data to the converter |
| dac_sclk | output | 1 | Shift clock to the converter |
| dac_le | output | 1 | Latch-enable strobe to the converter |
| busy | output | 1 | A load is in progress |
| done | output | 1 | One-cycle pulse when the strobe returns high |
| error | output | 1 | Last accepted request was refused |

## Verification
A wrong phase counter or shift register shows up at the ports within one phase period. The clock, data and strobe pattern then departs from the expected 41-phase stream, so the bench compares those three lines on every clock cycle of each load. A divider that stops counting, or that loses its captured count, moves every later phase boundary. A stuck busy or done bit is seen within one cycle, because the done pulse, the fall of busy and the rise of the strobe must all land in the same cycle. A wrong range or slot decision shows in the cycle after the handshake, as a spurious shift clock or a missing error flag.

// File: rtl/dwl_pkg.sv
// Shared types and constants of the serial DAC word loader.
// Assumes: nothing beyond IEEE 1800-2017.
package dwl_pkg;
    // Controller state: idle with the strobe high, or running a load
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } dwl_state_t;

    // Minimum slot in phase periods: two phases per bit plus the take phase
    function automatic int unsigned min_slot(input int unsigned word_w);
        return 2 * word_w + 1;
    endfunction
endpackage

// File: rtl/dwl_phase_timer.sv
// Phase timer: measures phases of (limit+1) clock cycles while run is high.
// Assumes: limit is held stable by the caller for the whole run.
module dwl_phase_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] limit,
    output logic             phase_end
);
    logic [DIV_W-1:0] cnt_q;

    // Last cycle of the current phase
    assign phase_end = run && (cnt_q == limit);

    // Count cycles within a phase; restart at phase ends and while stopped
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '0;
        else if (!run || phase_end) cnt_q <= '0;
        else                        cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/dwl_req_check.sv
// Request checker: decides whether a value fits the signed word and the slot is long enough.
// Assumes: value is two's complement with IN_W >= WORD_W.
module dwl_req_check #(
    parameter int WORD_W = 20,
    parameter int IN_W   = 24,
    parameter int SLOT_W = 12
) (
    input  logic [IN_W-1:0]   value,
    input  logic [SLOT_W-1:0] slot,
    output logic              ok
);
    localparam int TOP_W = IN_W - WORD_W + 1;
    localparam int unsigned MIN_SLOT = dwl_pkg::min_slot(WORD_W);

    logic [TOP_W-1:0] top_bits;
    logic             fits;
    logic             long_enough;

    // A value fits when all bits above the word's sign bit repeat that sign
    always_comb begin
        top_bits    = value[IN_W-1:WORD_W-1];
        fits        = (top_bits == '0) || (top_bits == '1);
        long_enough = (32'(slot) >= MIN_SLOT);
        ok          = fits && long_enough;
    end
endmodule

// File: rtl/dwl_shifter.sv
// Word shifter: holds the word being sent and presents its next bit.
// Assumes: load and shift are never high together.
module dwl_shifter #(
    parameter int WORD_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              shift,
    output logic              msb
);
    logic [WORD_W-1:0] sr_q;

    assign msb = sr_q[WORD_W-1];

    // Capture a new word, or move the next bit up to the top
    always_ff @(posedge clk) begin
        if (!rst_n)     sr_q <= '0;
        else if (load)  sr_q <= load_word;
        else if (shift) sr_q <= {sr_q[WORD_W-2:0], 1'b0};
    end
endmodule

// File: rtl/dac_word_loader.sv
// Serial DAC word loader: takes a checked signed value and writes it to a
// three-wire DAC, msb first, two phases per bit, then an all-low take phase.
// Sequence pulses run a zero load with the strobe low during the shift.
// Assumes: seq_start/seq_end are single-cycle pulses offered while idle.
module dac_word_loader #(
    parameter int WORD_W = 20,
    parameter int IN_W   = 24,
    parameter int DIV_W  = 8,
    parameter int SLOT_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seq_start,
    input  logic              seq_end,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [IN_W-1:0]   req_value,
    input  logic [SLOT_W-1:0] req_slot,
    input  logic [DIV_W-1:0]  div_count,
    output logic              dac_sdata,
    output logic              dac_sclk,
    output logic              dac_le,
    output logic              busy,
    output logic              done,
    output logic              error
);
    import dwl_pkg::*;

    localparam int SHIFT_PHASES = 2 * WORD_W;
    localparam int PH_W         = $clog2(SHIFT_PHASES + 1);
    localparam logic [PH_W-1:0] TAKE_PHASE = PH_W'(SHIFT_PHASES);

    dwl_state_t        state_q;
    logic [PH_W-1:0]   phase_q;
    logic [DIV_W-1:0]  div_q;
    logic              zero_mode_q;
    logic              done_q;
    logic              error_q;

    logic seq_pulse, idle, accept, req_ok, start_zero, start_data, start;
    logic phase_end, shift_bit, data_bit;

    assign idle       = (state_q == ST_IDLE);
    assign seq_pulse  = seq_start || seq_end;
    assign req_ready  = idle && !seq_pulse;
    assign accept     = req_valid && req_ready;
    assign start_zero = idle && seq_pulse;
    assign start_data = accept && req_ok;
    assign start      = start_zero || start_data;
    assign shift_bit  = phase_end && phase_q[0] && (phase_q < TAKE_PHASE);

    dwl_req_check #(.WORD_W(WORD_W), .IN_W(IN_W), .SLOT_W(SLOT_W)) u_check (
        .value (req_value),
        .slot  (req_slot),
        .ok    (req_ok)
    );

    dwl_phase_timer #(.DIV_W(DIV_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (!idle),
        .limit     (div_q),
        .phase_end (phase_end)
    );

    dwl_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start),
        .load_word (start_zero ? '0 : req_value[WORD_W-1:0]),
        .shift     (shift_bit),
        .msb       (data_bit)
    );

    // Sequence the load: start, step through phases, return to idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            phase_q     <= '0;
            div_q       <= '0;
            zero_mode_q <= 1'b0;
            done_q      <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (idle) begin
                if (start) begin
                    state_q     <= ST_SHIFT;
                    phase_q     <= '0;
                    div_q       <= div_count;
                    zero_mode_q <= start_zero;
                end
            end else if (phase_end) begin
                if (phase_q == TAKE_PHASE) begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                end else begin
                    phase_q <= phase_q + 1'b1;
                end
            end
        end
    end

    // Error flag: refreshed by every accepted request
    always_ff @(posedge clk) begin
        if (!rst_n)      error_q <= 1'b0;
        else if (accept) error_q <= !req_ok;
    end

    // Drive the converter lines from the current phase
    always_comb begin
        if (idle) begin
            dac_sdata = 1'b0;
            dac_sclk  = 1'b0;
            dac_le    = 1'b1;
        end else if (phase_q == TAKE_PHASE) begin
            dac_sdata = 1'b0;
            dac_sclk  = 1'b0;
            dac_le    = 1'b0;
        end else begin
            dac_sdata = data_bit;
            dac_sclk  = !phase_q[0];
            dac_le    = !zero_mode_q;
        end
    end

    assign busy  = !idle;
    assign done  = done_q;
    assign error = error_q;
endmodule

// File: rtl/dwl_checker.sv
// Protocol checker for the serial DAC word loader; attached by bind below.
// Assumes: signals are sampled at the rising clock edge.
module dwl_checker #(
    parameter int WORD_W = 20,
    parameter int IN_W   = 24,
    parameter int PH_W   = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic [IN_W-1:0] req_value,
    input logic            dac_sclk,
    input logic            dac_le,
    input logic            busy,
    input logic            done,
    input logic            error,
    input logic            zero_mode,
    input logic [PH_W-1:0] phase
);
    localparam longint HI = (longint'(1) <<< (WORD_W - 1)) - 1;
    localparam longint LO = -(longint'(1) <<< (WORD_W - 1));

    logic   handshake;
    longint sval;
    assign handshake = req_valid && req_ready;
    assign sval      = longint'($signed(req_value));

    // Shift clock only runs during a load
    assert_sclk_in_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dac_sclk |-> busy);

    // Strobe high through the data shift phases
    assert_le_high_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !zero_mode && phase < PH_W'(2 * WORD_W)) |-> dac_le);

    // End of load: done with busy falling and strobe high
    assert_done_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done && dac_le));

    assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // Out-of-range value: refused, no load
    assert_range_refuse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (handshake && (sval > HI || sval < LO)) |=> (!busy && error));

    // Strobe low while a zero load shifts
    assert_zero_le_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && zero_mode) |-> !dac_le);

    // Ready only when idle
    assert_ready_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !busy);

    // Error holds until a request is taken
    assert_error_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (error && !handshake) |=> error);
endmodule

bind dac_word_loader dwl_checker #(
    .WORD_W (WORD_W),
    .IN_W   (IN_W),
    .PH_W   ($clog2(2 * WORD_W + 1))
) u_dwl_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_value (req_value),
    .dac_sclk  (dac_sclk),
    .dac_le    (dac_le),
    .busy      (busy),
    .done      (done),
    .error     (error),
    .zero_mode (zero_mode_q),
    .phase     (phase_q)
);

// File: tb/test_dac_word_loader.sv
// Directed bench for the serial DAC word loader.
module test_dac_word_loader;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seq_start = 1'b0, seq_end = 1'b0, req_valid = 1'b0;
    logic [23:0] req_value = '0;
    logic [11:0] req_slot = 12'd41;
    logic [7:0]  div_count = 8'd0;
    logic        req_ready, dac_sdata, dac_sclk, dac_le, busy, done, error;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dac_word_loader i_dac_word_loader (
        .clk(clk), .rst_n(rst_n), .seq_start(seq_start), .seq_end(seq_end),
        .req_valid(req_valid), .req_ready(req_ready), .req_value(req_value),
        .req_slot(req_slot), .div_count(div_count), .dac_sdata(dac_sdata),
        .dac_sclk(dac_sclk), .dac_le(dac_le), .busy(busy), .done(done),
        .error(error)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Follow one load from the cycle after its handshake; optionally disturb it.
    task automatic run_stream(input logic [19:0] w, input bit zero, input int d,
                              input bit disturb, input string req);
        for (int n = 0; n < 41 * (d + 1); n++) begin
            @(negedge clk);
            if (n == 0) begin
                req_valid = 1'b0; seq_start = 1'b0; seq_end = 1'b0;
            end
            if (disturb && n == 3) begin
                req_valid = 1'b1; req_value = 24'h012345; seq_end = 1'b1;
                div_count = 8'(d + 3);
                #1 check("R9 ready low while busy", req_ready, 0);
            end
            if (disturb && n == 4) begin
                req_valid = 1'b0; seq_end = 1'b0;
            end
            begin
                int p = n / (d + 1);
                logic [3:0] exp;
                if (p < 40) exp = {(zero ? 1'b0 : w[19 - p / 2]), (p % 2 == 0), !zero, 1'b1};
                else        exp = 4'b0001;
                check(req, {dac_sdata, dac_sclk, dac_le, busy}, exp);
            end
        end
        @(negedge clk);
        check("R4 done and strobe high after take phase", {done, dac_le, busy}, 3'b110);
        @(negedge clk);
        check("R4 done lasts one cycle", {done, busy}, 2'b00);
    endtask

    task automatic data_load(input logic [23:0] v, input int d, input int slot,
                             input bit disturb, input string req);
        @(negedge clk);
        div_count = 8'(d); req_slot = 12'(slot); req_value = v; req_valid = 1'b1;
        #1 check("R9 ready while idle", req_ready, 1);
        run_stream(v[19:0], 1'b0, d, disturb, req);
        div_count = 8'(d);
    endtask

    task automatic t_reset();
        check("R1 reset outputs", {dac_le, dac_sclk, dac_sdata, req_ready, busy, done, error},
              7'b1001000);
    endtask

    task automatic t_zero(input bit use_end, input int d);
        @(negedge clk);
        div_count = 8'(d);
        if (use_end) seq_end = 1'b1; else seq_start = 1'b1;
        run_stream(20'h0, 1'b1, d, 1'b0, "R8 zero load stream");
    endtask

    task automatic t_refuse(input logic [23:0] v, input int slot, input string req);
        @(negedge clk);
        req_value = v; req_slot = 12'(slot); req_valid = 1'b1; div_count = 8'd0;
        @(negedge clk);
        req_valid = 1'b0;
        check(req, {error, busy, dac_le, dac_sclk}, 4'b1010);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(req, {busy, dac_le, dac_sclk, error}, 4'b0101);
        end
    endtask

    task automatic t_error_clear();
        // error is set by the preceding refusal; an accepted load clears it
        check("R10 error held before next request", error, 1);
        @(negedge clk);
        req_value = 24'h000001; req_slot = 12'd100; req_valid = 1'b1; div_count = 8'd0;
        @(negedge clk);
        req_valid = 1'b0;
        check("R10 error cleared by accepted request", {error, busy}, 2'b01);
        repeat (41) @(negedge clk);
        check("R10 load after clear finished", {done, busy}, 2'b10);
        @(negedge clk);
    endtask

    task automatic t_priority();
        @(negedge clk);
        div_count = 8'd0; req_value = 24'h000155; req_slot = 12'd50;
        req_valid = 1'b1; seq_end = 1'b1;
        #1 check("R11 ready low on sequence pulse", req_ready, 0);
        run_stream(20'h0, 1'b1, 0, 1'b0, "R11 zero load wins");
        check("R11 request not taken", {busy, error}, 2'b00);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_zero(1'b0, 1);
        data_load(24'h05A3C6, 0, 41, 1'b0, "R2 R3 stream, slot 41 boundary R7");
        data_load(24'h07FFFF, 2, 60, 1'b0, "R2 max value, R5 period 3");
        data_load(24'hF80000, 1, 41, 1'b0, "R2 min value R6");
        data_load(24'hFFFFFF, 1, 200, 1'b1, "R5 R9 disturbed load unchanged");
        t_refuse(24'h080000, 100, "R6 above max refused");
        t_refuse(24'hF7FFFF, 100, "R6 below min refused");
        t_refuse(24'h000010, 40, "R7 short slot refused");
        t_error_clear();
        t_zero(1'b1, 0);
        t_priority();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule